// File: doc/BRIEF.md
# Armed Trigger Circular Capture Controller

This block steers the writing of converter samples into a circular capture memory. While the write-enable control bit is set, every sample strobe produces one memory write at the current address. The 15-bit address then advances and wraps from its top value to zero. Because the buffer is overwritten continuously, it always holds the most recent history of the signal.

When the arm control bit is set, the block accepts a trigger from either of two lines: a sweep-start line or the output of a video-level comparator. From that moment a 16-bit post-trigger count, loaded from a programmable input, limits how many more samples are written. When that count is used up, writing freezes. The block then reports completion, the address of the first post-trigger sample and the address of the last sample written, so the record can be read back around the trigger point.

Top module: `trig_capture_ctrl`

## Requirements
- R1: A memory write (`memWe` high) happens only in a cycle where `sampleValid` is 1 and `writeEn` has been 1 since the previous cycle or longer. The first write comes in the cycle after `writeEn` rises. While `writeEn` is 0 no write occurs and `memAddr` holds its value.
- R2: `memAddr` is the address of the write in the current cycle. It advances by one after each write and wraps from 32767 to 0.
- R3: A trigger is a rising edge, relative to the previous cycle, on `sweepTrig` or `videoTrig`. It is accepted only while `armEn` is 1 and writing has not yet been triggered. With `armEn` at 0, pulses have no effect on `done` or on how many samples are written.
- R4: Only the first accepted trigger counts. Later edges on either line are ignored, even across clearing and setting `writeEn` again, until `armEn` has been 0 for at least one cycle and is set again. Edges on both lines in the same cycle form one trigger.
- R5: `postCount` is sampled in the trigger cycle. After the trigger, exactly that many further samples are written, and cycles without `sampleValid` do not count. `done` rises in the cycle after the final write. From then on no write occurs and `memAddr` holds.
- R6: If `postCount` is 0 at the trigger, no sample after the trigger cycle is written and `done` rises in the next cycle.
- R7: `trigAddr` is the address of the first post-trigger sample. If the trigger cycle also writes a sample at address A, it is A+1. If it does not, it is the current `memAddr`.
- R8: `endAddr` is the address of the most recently written sample, and it is held unchanged while `done` is 1.
- R9: `done` and `trigAddr` remain steady while `writeEn` stays 1. Clearing `writeEn` drops `done` in the next cycle.
- R10: After reset, `memAddr`, `trigAddr` and `endAddr` are 0, and `memWe` and `done` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rstN | input | 1 | Asynchronous reset, active low |
| writeEn | input | 1 | Control bit: sampling into memory enabled |
| armEn | input | 1 | Control bit: trigger acceptance enabled |
| sampleValid | input | 1 | A converter sample is present this cycle |
| sweepTrig | input | 1 | Sweep-start trigger line |
| videoTrig | input | 1 | Video-level comparator trigger line |
| postCount | input | 16 | Number of samples to write after the trigger |
| memAddr | output | 15 | Capture memory write address |
| memWe | output | 1 | Capture memory write enable |
| trigAddr | output | 15 | Address of the first post-trigger sample |
| endAddr | output | 15 | Address of the last sample written |
| done | output | 1 | Post-trigger capture complete |

## Verification
A trigger edge and a sample write can fall in the same cycle. That cycle decides whether the sample belongs to the pre-trigger history and where the trigger address points. The bench drives a trigger pulse once with `sampleValid` high and once with it low. It expects a trigger address one past the written address in the first case and equal to the current address in the second. The scoreboard confirms that the post-trigger window then holds exactly the programmed number of writes. The final post-trigger write and the raising of `done` are also neighbours: the monitor flags any write seen after the last expected address.

// File: rtl/cap_pkg.sv
package cap_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_PRE  = 2'd1,
    ST_POST = 2'd2,
    ST_DONE = 2'd3
  } capState_t;

  typedef struct packed {
    logic stepWe;   // a sample is written this cycle
    logic trigHit;  // trigger accepted this cycle
    logic decPost;  // one post-trigger sample consumed
  } capStrobe_t;

endpackage

// File: rtl/cap_ctrl.sv
module cap_ctrl
  import cap_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       writeEn,
  input  logic       armEn,
  input  logic       sampleValid,
  input  logic       sweepTrig,
  input  logic       videoTrig,
  input  logic       loadZero,
  input  logic       postLast,
  output capStrobe_t stb,
  output logic       memWe,
  output logic       done
);

  capState_t stateQ, stateD;
  logic sweepQ, videoQ, spentQ, spentD;
  logic trigRise, qualTrig, weNow;

  always_comb begin
    trigRise = (sweepTrig & ~sweepQ) | (videoTrig & ~videoQ);
    weNow    = writeEn && sampleValid &&
               (stateQ == ST_PRE || stateQ == ST_POST);
    qualTrig = writeEn && armEn && !spentQ && trigRise && (stateQ == ST_PRE);
    spentD   = armEn ? (spentQ | qualTrig) : 1'b0;

    stateD = stateQ;
    if (!writeEn) begin
      stateD = ST_IDLE;
    end else begin
      case (stateQ)
        ST_IDLE: stateD = ST_PRE;
        ST_PRE:  if (qualTrig) stateD = loadZero ? ST_DONE : ST_POST;
        ST_POST: if (weNow && postLast) stateD = ST_DONE;
        default: stateD = stateQ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ <= ST_IDLE;
      sweepQ <= 1'b0;
      videoQ <= 1'b0;
      spentQ <= 1'b0;
    end else begin
      stateQ <= stateD;
      sweepQ <= sweepTrig;
      videoQ <= videoTrig;
      spentQ <= spentD;
    end
  end

  assign stb.stepWe  = weNow;
  assign stb.trigHit = qualTrig;
  assign stb.decPost = weNow && (stateQ == ST_POST);
  assign memWe       = weNow;
  assign done        = (stateQ == ST_DONE);

  AST_WE_NEEDS_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    memWe |-> (writeEn && $past(writeEn)));  // R1

  AST_TRIG_NEEDS_ARM: assert property (@(posedge clk) disable iff (!rstN)
    ($past(stateQ) == ST_PRE && (stateQ == ST_POST || stateQ == ST_DONE))
      |-> $past(armEn));  // R3

  AST_DONE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !memWe);  // R5

  AST_DONE_DROPS: assert property (@(posedge clk) disable iff (!rstN)
    !writeEn |=> !done);  // R9

endmodule

// File: rtl/cap_datapath.sv
module cap_datapath
  import cap_pkg::*;
#(
  parameter int ADDR_W = 15,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  capStrobe_t        stb,
  input  logic [CNT_W-1:0]  postCount,
  output logic [ADDR_W-1:0] memAddr,
  output logic [ADDR_W-1:0] trigAddr,
  output logic [ADDR_W-1:0] endAddr,
  output logic              loadZero,
  output logic              postLast
);

  localparam logic [ADDR_W-1:0] ADDR_MAX = '1;
  localparam logic [CNT_W-1:0]  CNT_ONE  = CNT_W'(1);

  logic [ADDR_W-1:0] addrQ, trigAddrQ, endAddrQ, addrNext;
  logic [CNT_W-1:0]  postQ;

  assign addrNext = addrQ + 1'b1;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrQ     <= '0;
      postQ     <= '0;
      trigAddrQ <= '0;
      endAddrQ  <= '0;
    end else begin
      if (stb.stepWe) begin
        addrQ    <= addrNext;
        endAddrQ <= addrQ;
      end
      if (stb.trigHit) begin
        postQ     <= postCount;
        trigAddrQ <= stb.stepWe ? addrNext : addrQ;
      end else if (stb.decPost) begin
        postQ <= postQ - 1'b1;
      end
    end
  end

  assign memAddr  = addrQ;
  assign trigAddr = trigAddrQ;
  assign endAddr  = endAddrQ;
  assign loadZero = (postCount == '0);
  assign postLast = (postQ == CNT_ONE);

  AST_ADDR_WRAP: assert property (@(posedge clk) disable iff (!rstN)
    (stb.stepWe && addrQ == ADDR_MAX) |=> (addrQ == '0));  // R2

  AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !stb.stepWe |=> $stable(addrQ));  // R1

  AST_POST_DEC: assert property (@(posedge clk) disable iff (!rstN)
    stb.decPost |=> (postQ == $past(postQ) - 1'b1));  // R5

  AST_END_FOLLOWS: assert property (@(posedge clk) disable iff (!rstN)
    stb.stepWe |=> (endAddrQ == $past(addrQ)));  // R8

endmodule

// File: rtl/trig_capture_ctrl.sv
module trig_capture_ctrl
  import cap_pkg::*;
#(
  parameter int ADDR_W = 15,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              writeEn,
  input  logic              armEn,
  input  logic              sampleValid,
  input  logic              sweepTrig,
  input  logic              videoTrig,
  input  logic [CNT_W-1:0]  postCount,
  output logic [ADDR_W-1:0] memAddr,
  output logic              memWe,
  output logic [ADDR_W-1:0] trigAddr,
  output logic [ADDR_W-1:0] endAddr,
  output logic              done
);

  capStrobe_t stb;
  logic loadZero, postLast;

  cap_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .writeEn(writeEn), .armEn(armEn),
    .sampleValid(sampleValid), .sweepTrig(sweepTrig), .videoTrig(videoTrig),
    .loadZero(loadZero), .postLast(postLast), .stb(stb),
    .memWe(memWe), .done(done)
  );

  cap_datapath #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .postCount(postCount),
    .memAddr(memAddr), .trigAddr(trigAddr), .endAddr(endAddr),
    .loadZero(loadZero), .postLast(postLast)
  );

endmodule

// File: tb/sim_trig_capture_ctrl.sv
module sim_trig_capture_ctrl;

  localparam int DEPTH = 32768;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic writeEn = 1'b0, armEn = 1'b0, sampleValid = 1'b0;
  logic sweepTrig = 1'b0, videoTrig = 1'b0;
  logic [15:0] postCount = '0;
  logic [14:0] memAddr, trigAddr, endAddr;
  logic memWe, done;

  int checks = 0;
  int errors = 0;
  int expAddr = 0;
  int expQ[$];
  bit finished = 1'b0;

  always #5 clk = ~clk;

  trig_capture_ctrl u0 (
    .clk(clk), .rstN(rstN), .writeEn(writeEn), .armEn(armEn),
    .sampleValid(sampleValid), .sweepTrig(sweepTrig), .videoTrig(videoTrig),
    .postCount(postCount), .memAddr(memAddr), .memWe(memWe),
    .trigAddr(trigAddr), .endAddr(endAddr), .done(done)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // driver: one cycle of stimulus, predicted write pushed to the scoreboard
  task automatic tick(input logic sv, input logic sw, input logic vid, input bit expW);
    sampleValid = sv;
    sweepTrig   = sw;
    videoTrig   = vid;
    if (expW) begin
      expQ.push_back(expAddr);
      expAddr = (expAddr + 1) % DEPTH;
    end
    @(posedge clk);
    #1;
  endtask

  // monitor: compare each observed write against the scoreboard
  initial begin
    forever begin
      @(negedge clk);
      if (rstN && memWe) begin
        checks++;
        if (expQ.size() == 0) begin
          errors++;
          $display("FAIL R1/R5: unexpected write actual addr %0d expected none", memAddr);
        end else begin
          int e;
          e = expQ.pop_front();
          if (int'(memAddr) != e) begin
            errors++;
            $display("FAIL R2: write addr actual %0d expected %0d", memAddr, e);
          end
        end
      end
    end
  end

  initial begin
    #1500000;
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int a;
    int b;
    int c;
    int n;
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    // R10 reset state
    chk("R10 memAddr", memAddr, 0);
    chk("R10 memWe", memWe, 0);
    chk("R10 done", done, 0);
    chk("R10 trigAddr", trigAddr, 0);
    chk("R10 endAddr", endAddr, 0);

    // R1: no writes with writeEn low
    repeat (5) tick(1, 0, 0, 0);
    chk("R1 addr held while write off", memAddr, 0);

    // R1: first write one cycle after writeEn rises
    writeEn = 1'b1;
    tick(1, 0, 0, 0);
    repeat (10) tick(1, 0, 0, 1);
    tick(0, 0, 0, 0);
    chk("R2 addr after ten writes", memAddr, 10);
    chk("R8 endAddr last write", endAddr, 9);

    // R3: triggers ignored while unarmed
    tick(1, 1, 0, 1);
    tick(1, 0, 0, 1);
    tick(1, 0, 1, 1);
    repeat (4) tick(1, 0, 0, 1);
    chk("R3 unarmed no done", done, 0);

    // R5/R7: trigger together with a write, six post samples with gaps
    armEn = 1'b1;
    postCount = 16'd6;
    tick(1, 0, 0, 1);
    a = expAddr;
    tick(1, 0, 1, 1);
    postCount = 16'd99;  // sampled at trigger only
    repeat (3) tick(1, 0, 0, 1);
    repeat (2) tick(0, 0, 0, 0);
    tick(1, 1, 0, 1);    // R4 edge during post phase ignored
    tick(1, 0, 0, 1);
    chk("R5 done not yet", done, 0);
    tick(1, 0, 0, 1);
    chk("R5 done after final write", done, 1);
    chk("R7 trigAddr with write", trigAddr, (a + 1) % DEPTH);
    chk("R8 endAddr at done", endAddr, (a + 6) % DEPTH);
    repeat (3) tick(1, 0, 1, 0);
    chk("R5 addr frozen", memAddr, expAddr);
    chk("R8 endAddr held", endAddr, (a + 6) % DEPTH);
    chk("R9 done held", done, 1);
    chk("R9 trigAddr held", trigAddr, (a + 1) % DEPTH);

    // R9: clearing writeEn drops done
    writeEn = 1'b0;
    tick(1, 0, 0, 0);
    chk("R9 done cleared", done, 0);

    // R4: still spent after write cycling
    writeEn = 1'b1;
    tick(0, 0, 0, 0);
    repeat (3) tick(1, 0, 0, 1);
    tick(1, 1, 0, 1);
    repeat (5) tick(1, 0, 0, 1);
    chk("R4 spent trigger ignored", done, 0);

    // R4/R7: rearm, both lines at once, trigger without a write
    armEn = 1'b0;
    tick(1, 0, 0, 1);
    armEn = 1'b1;
    tick(1, 0, 0, 1);
    postCount = 16'd2;
    b = expAddr;
    tick(0, 1, 1, 0);
    tick(1, 0, 0, 1);
    tick(1, 1, 1, 1);
    tick(1, 0, 0, 0);
    chk("R4 rearmed trigger done", done, 1);
    chk("R7 trigAddr without write", trigAddr, b);
    chk("R8 endAddr two post", endAddr, (b + 1) % DEPTH);

    // R6: zero post count
    writeEn = 1'b0;
    armEn = 1'b0;
    tick(0, 0, 0, 0);
    writeEn = 1'b1;
    armEn = 1'b1;
    postCount = 16'd0;
    tick(0, 0, 0, 0);
    tick(1, 0, 0, 1);
    c = expAddr;
    tick(1, 1, 0, 1);
    chk("R6 done next cycle", done, 1);
    tick(1, 0, 0, 0);
    chk("R6 endAddr trigger sample", endAddr, c);
    chk("R6 trigAddr", trigAddr, (c + 1) % DEPTH);

    // R2: run across the wrap
    writeEn = 1'b0;
    armEn = 1'b0;
    tick(0, 0, 0, 0);
    writeEn = 1'b1;
    tick(0, 0, 0, 0);
    n = (DEPTH - expAddr) + 3;
    for (int i = 0; i < n; i++) tick(1, 0, 0, 1);
    tick(0, 0, 0, 0);
    chk("R2 addr after wrap", memAddr, 3);
    chk("R8 endAddr after wrap", endAddr, 2);

    tick(0, 0, 0, 0);
    @(negedge clk);
    chk("R1 all expected writes seen", expQ.size(), 0);
    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule